// File: doc/BRIEF.md
# Board Reset Cause Recorder with Source Masking

This block sits on a board controller and watches eight reset-request lines arriving from different parts of the board. Each line is brought into the local clock domain through a two-flop synchronizer. A request that is allowed through raises one combined system reset output. The output stays high for a fixed number of cycles after the last allowed request goes away. Each allowed request also sets its own bit in a sticky cause register, so that after the board comes back, software can find out what reset it.

Software uses a one-bit register index with a write strobe and write data, and it sees the selected register on a combinational read bus. Index 0 selects the cause register. Any write to it clears every cause bit, whatever the data. Index 1 selects the enable mask. A 1 in the mask lets that source through. The power-on, legacy-bus and management-controller sources cannot be turned off by the mask.

Both registers are reset only by the power-on input. The system reset this block drives does not clear them, so the record survives the reset it describes.

Top module: `reset_cause_unit`

## Requirements
- R1: While `por_n` is low and right after it rises, the cause register (index 0) reads 0x01 and the mask register (index 1) reads 0xFE.
- R2: Cause bit positions are: 0 power-on, 1 watchdog, 2 front-panel button, 3 mezzanine slot, 4 rear transition module, 5 host-bridge CPU reset, 6 legacy PCI bus, 7 management controller. An enabled request held for at least one cycle sets its bit, and the bit reads 1 on the third rising edge after the request is sampled high.
- R3: Cause bits are sticky. Once set, a bit stays 1 until software clears it, so requests from several sources accumulate.
- R4: A write to index 0 clears all cause bits in the next cycle, whatever the value of `reg_wdata`.
- R5: If an enabled synchronized request is active in the same cycle as a clear, that source's bit reads 1 after the clear.
- R6: Mask bits 1 to 5 are written from `reg_wdata[5:1]` by a write to index 1. A 1 enables the source and a 0 disables it.
- R7: Mask bit 0 always reads 0, and mask bits 6 and 7 always read 1. Writes to these bits have no effect.
- R8: A disabled source neither sets its cause bit nor asserts `sys_rst_o`.
- R9: Sources 0, 6 and 7 always set their cause bit and assert `sys_rst_o`, whatever the mask contents.
- R10: `sys_rst_o` rises on the third rising edge after an enabled request is first sampled. It stays high while the synchronized request is active and for 16 further cycles, so it is seen high for 18 cycles after the request drops.
- R11: `sys_rst_o` is high during power-on reset and for 16 cycles after `por_n` is released.
- R12: Neither register changes because `sys_rst_o` is asserted. Only register writes and requests alter them.

Index encoding: `reg_idx` = 0 selects the cause register and 1 selects the mask register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| req_i | input | 8 | Asynchronous reset requests, one per source, active high |
| reg_idx | input | 1 | Register index: 0 cause, 1 mask |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sys_rst_o | output | 1 | Combined, stretched system reset, active high |

## Verification
The assertions assume that `reg_wr`, `reg_idx` and `reg_wdata` are synchronous to `clk` and already have known values when `por_n` is released. They also assume that requests may arrive at any time, because the synchronizer absorbs their timing. The stimulus changes every input one nanosecond after a rising edge and holds `por_n` low from time zero, so every register starts from a known value. Requests are held for whole cycles, and the simultaneous-clear case is made by keeping a request high across the write.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;
    localparam int NSRC = 8;

    // bit positions of the sources
    localparam int SRC_POWER  = 0;
    localparam int SRC_WDOG   = 1;
    localparam int SRC_BUTTON = 2;
    localparam int SRC_MEZZ   = 3;
    localparam int SRC_REAR   = 4;
    localparam int SRC_HOSTCPU = 5;
    localparam int SRC_LEGBUS = 6;
    localparam int SRC_MGMT   = 7;

    // sources that the mask cannot turn off
    localparam logic [NSRC-1:0] FIXED_ON = (NSRC'(1) << SRC_POWER)
                                         | (NSRC'(1) << SRC_LEGBUS)
                                         | (NSRC'(1) << SRC_MGMT);
    // mask bits software may write
    localparam logic [NSRC-1:0] MASK_RW  = ~FIXED_ON;
    // mask bits that read as 1 without storage (bit 0 reads 0)
    localparam logic [NSRC-1:0] MASK_RD1 = FIXED_ON & ~(NSRC'(1) << SRC_POWER);

    localparam logic IDX_CAUSE = 1'b0;
    localparam logic IDX_MASK  = 1'b1;

    typedef struct packed {
        logic [NSRC-1:0] cause;
        logic [NSRC-1:0] mask;
    } regs_t;
endpackage

// File: rtl/rcu_sync.sv
module rcu_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= '0;
                else        pipe_q[g] <= pipe_d[g];
            end
        end
    endgenerate

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rcu_stretch.sv
module rcu_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic hold_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig_i)              cnt_d = LOAD;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    // loaded on power-on so the output is high through and after it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LOAD;
        else        cnt_q <= cnt_d;
    end

    assign hold_o = (cnt_q != '0);
endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
    import reset_cause_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            reg_idx,
    input  logic            reg_wr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    output logic            sys_rst_o
);
    localparam logic [NSRC-1:0] CAUSE_INIT = NSRC'(1) << SRC_POWER;

    regs_t           st_d, st_q;
    logic [NSRC-1:0] req_s;
    logic [NSRC-1:0] live;
    logic [NSRC-1:0] cause_w;
    logic [NSRC-1:0] mask_w;

    rcu_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (por_n),
        .async_i (req_i),
        .sync_o  (req_s)
    );

    // requests allowed through: stored enables plus fixed sources
    assign live = req_s & (st_q.mask | FIXED_ON);

    always_comb begin
        st_d = st_q;
        if (reg_wr && reg_idx == IDX_CAUSE) st_d.cause = '0;
        st_d.cause = st_d.cause | live;
        if (reg_wr && reg_idx == IDX_MASK)
            st_d.mask = reg_wdata & MASK_RW;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.cause <= CAUSE_INIT;
            st_q.mask  <= MASK_RW;
        end else begin
            st_q <= st_d;
        end
    end

    rcu_stretch #(.HOLD(HOLD_CYCLES)) u_stretch (
        .clk    (clk),
        .rst_n  (por_n),
        .trig_i (|live),
        .hold_o (sys_rst_o)
    );

    assign cause_w   = st_q.cause;
    assign mask_w    = st_q.mask;
    assign reg_rdata = (reg_idx == IDX_MASK) ? ((mask_w & MASK_RW) | MASK_RD1)
                                             : cause_w;
endmodule

// File: rtl/rcu_checker.sv
module rcu_checker
    import reset_cause_pkg::*;
(
    input logic            clk,
    input logic            por_n,
    input logic            reg_idx,
    input logic            reg_wr,
    input logic [NSRC-1:0] reg_rdata,
    input logic            sys_rst_o,
    input logic [NSRC-1:0] req_s,
    input logic [NSRC-1:0] cause_w,
    input logic [NSRC-1:0] mask_w
);
    // R3
    sticky_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$past(reg_wr && reg_idx == IDX_CAUSE) |-> ((cause_w & $past(cause_w)) == $past(cause_w)));

    // R2
    new_cause_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        (|(cause_w & ~$past(cause_w))) |-> sys_rst_o);

    // R12
    mask_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$past(reg_wr && reg_idx == IDX_MASK) |-> $stable(mask_w));

    // R9
    fixed_src_chk: assert property (@(posedge clk) disable iff (!por_n)
        (|(req_s & FIXED_ON)) |=> sys_rst_o);

    // R7
    mask_fixed_read_chk: assert property (@(posedge clk) disable iff (!por_n)
        (reg_idx == IDX_MASK) |-> (reg_rdata[0] == 1'b0 && reg_rdata[7:6] == 2'b11));
endmodule

bind reset_cause_unit rcu_checker u_rcu_chk (
    .clk       (clk),
    .por_n     (por_n),
    .reg_idx   (reg_idx),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .sys_rst_o (sys_rst_o),
    .req_s     (req_s),
    .cause_w   (cause_w),
    .mask_w    (mask_w)
);

// File: tb/reset_cause_unit_bench.sv
`timescale 1ns/1ps
module reset_cause_unit_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       reg_idx = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sys_rst_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    reset_cause_unit u_reset_cause_unit (
        .clk(clk), .por_n(por_n), .req_i(req_i), .reg_idx(reg_idx),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sys_rst_o(sys_rst_o)
    );

    // behavioural reference model
    logic [7:0] m_s1, m_s2, m_cause;
    logic [5:1] m_en;
    int         m_cnt;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_s1 = 0; m_s2 = 0; m_cause = 8'h01; m_en = 5'h1F; m_cnt = 16;
        end else begin
            logic [7:0] act;
            act = m_s2 & {2'b11, m_en, 1'b1};
            if (reg_wr && !reg_idx) m_cause = 0;
            m_cause = m_cause | act;
            if (reg_wr && reg_idx) m_en = reg_wdata[5:1];
            if (act != 0) m_cnt = 16;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_s2 = m_s1;
            m_s1 = req_i;
        end
    end

    function automatic logic [7:0] m_read();
        return reg_idx ? {2'b11, m_en, 1'b0} : m_cause;
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk("R10 rst model", {7'd0, sys_rst_o}, {7'd0, m_cnt > 0});
            chk("R2 read model", reg_rdata, m_read());
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic rd(logic idx, output logic [7:0] v);
        reg_idx = idx;
        @(negedge clk);
        v = reg_rdata;
        @(posedge clk); #1;
    endtask

    task automatic wr(logic idx, logic [7:0] d);
        reg_idx = idx; reg_wr = 1; reg_wdata = d;
        step();
        reg_wr = 0;
    endtask

    task automatic pulse(int src);
        req_i[src] = 1'b1; step(); req_i[src] = 1'b0;
        step(4);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        while (cyc < 200000) begin @(posedge clk); cyc++; end
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int hi;
        step(3);
        chk("R11 rst during por", {7'd0, sys_rst_o}, 8'd1);
        @(posedge clk); #1; por_n = 1;
        rd(0, v); chk("R1 cause default", v, 8'h01);
        rd(1, v); chk("R1 mask default", v, 8'hFE);
        hi = 2;
        while (sys_rst_o) begin step(); hi++; end
        // R11: high 16 cycles after release (2 spent in reads, counted above)
        chk("R11 por stretch", 8'(hi), 8'd16);

        wr(0, 8'h00); rd(0, v); chk("R4 clear any data", v, 8'h00);
        pulse(1);     rd(0, v); chk("R2 watchdog bit", v, 8'h02);
        pulse(4);     rd(0, v); chk("R3 accumulate", v, 8'h12);
        rd(1, v); chk("R12 mask kept across reset", v, 8'hFE);
        step(25);
        rd(0, v); chk("R12 cause kept across reset", v, 8'h12);
        wr(0, 8'hA5); rd(0, v); chk("R4 clear nonzero data", v, 8'h00);

        wr(1, 8'h00); rd(1, v); chk("R7 fixed mask bits", v, 8'hC0);
        req_i[3] = 1; step(6); req_i[3] = 0;
        chk("R8 masked no reset", {7'd0, sys_rst_o}, 8'd0);
        rd(0, v); chk("R8 masked no cause", v, 8'h00);

        pulse(6); pulse(7); pulse(0);
        rd(0, v); chk("R9 fixed sources", v, 8'hC1);
        step(25);

        wr(1, 8'hFF); rd(1, v); chk("R6 R7 mask write", v, 8'hFE);
        wr(1, 8'h08); rd(1, v); chk("R6 partial enable", v, 8'hC8);
        wr(0, 8'h00);
        pulse(2); rd(0, v); chk("R6 disabled button", v, 8'h00);
        pulse(3); rd(0, v); chk("R6 enabled mezz", v, 8'h08);
        wr(1, 8'hFF);

        req_i[5] = 1; step(4);
        wr(0, 8'h00);
        rd(0, v); chk("R5 clear vs event", v, 8'h20);
        req_i[5] = 0; step(25);

        req_i[2] = 1; step(5); req_i[2] = 0;
        hi = 0;
        @(negedge clk);
        while (sys_rst_o) begin hi++; @(negedge clk); end
        // R10: 2 sync cycles + 16 stretch cycles
        chk("R10 stretch length", 8'(hi), 8'd18);
        step(3);
        finish_run();
    end
endmodule